// File: doc/BRIEF.md
# Prescaled Fan PWM Generator

This block drives one fan-control PWM pin from two programmable registers. A control register picks one of two incoming clock-enable pulse streams, a fast one and a slow one. It also sets a divide ratio for the chosen stream. The divided tick advances an 8-bit counter that wraps every 256 ticks. Comparing that counter against a duty value produces the output. The code 00h gives a constant low and FFh gives a constant high.

Software writes and reads the two registers through a small address/data port. A controller outside the block can take over the duty value with an override flag and an override duty. While the override is on, a read of the duty address returns the duty that is actually in effect. Any change to the settings is applied only when a new 256-tick period starts, so the output never carries a shortened pulse.

Top module: `fan_pwm_gen`

## Requirements
- R1: The period is 256 divided ticks. For a duty value D from 01h to FEh, the output is high during the first D ticks of each period and low for the rest, so the high fraction is D/256.
- R2: A duty value of 00h keeps the output low for the whole period.
- R3: A duty value of FFh keeps the output high for the whole period, with no low tick.
- R4: Bit 7 of the control register (address 0) selects the tick source. 0 selects `tick_fast` and 1 selects `tick_slow`.
- R5: Bits 6:0 of the control register hold a value N, and the selected ticks are divided by N+1. N=0 passes every tick through and N=7Fh divides by 128.
- R6: After reset the control register reads 01h, the duty register reads FFh and the output is high.
- R7: When `wr_en` is high at a clock edge, `wdata` is stored in the control register if `addr`=0 or in the duty register if `addr`=1. `rdata` shows the register selected by `addr` combinationally.
- R8: A control or duty value written during a period has no effect on the output until the next period begins.
- R9: While `ovr_en` is high, the duty taken at each period start is `ovr_duty`, and a read of address 1 returns the duty in effect rather than the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast | input | 1 | Fast-rate clock-enable pulse |
| tick_slow | input | 1 | Slow-rate clock-enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 duty |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| ovr_en | input | 1 | Override enable |
| ovr_duty | input | 8 | Override duty value |
| pwm_out | output | 1 | PWM output |

## Verification
A fault in the period counter or in the divider shows up at the pin as a wrong count of high cycles in a full period window. The error is visible within one output period, which is 256 times the divide ratio times the source interval. A fault in how pending settings are taken shows up in two ways: a fresh duty changes the pulse in the middle of the period where it was written, or the new setting never appears at all. The bench aligns to a rising edge of the pin to catch both within two periods. A faulty read path shows up at once on `rdata`, above all while the override is on.

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int          CW       = 8,
  parameter logic [CW-1:0] PRE_RST  = 8'h01,
  parameter logic [CW-1:0] DUTY_RST = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_fast,
  input  logic          tick_slow,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic          ovr_en,
  input  logic [CW-1:0] ovr_duty,
  output logic          pwm_out
);
  localparam int PW = CW - 1;

  logic [CW-1:0] pre_reg, pre_act, duty_reg, duty_act, cnt;
  logic [PW-1:0] pcnt;

  wire src_tick = pre_act[PW] ? tick_slow : tick_fast;
  wire div_tick = src_tick && (pcnt == pre_act[PW-1:0]);
  wire wrap     = div_tick && (cnt == '1);
  wire [CW-1:0] duty_next = ovr_en ? ovr_duty : duty_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_reg  <= PRE_RST;
      duty_reg <= DUTY_RST;
    end else if (wr_en) begin
      if (addr) duty_reg <= wdata;
      else      pre_reg  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pcnt <= '0;
    else if (div_tick) pcnt <= '0;
    else if (src_tick) pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (div_tick) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_act  <= PRE_RST;
      duty_act <= DUTY_RST;
    end else if (wrap) begin
      pre_act  <= pre_reg;
      duty_act <= duty_next;
    end
  end

  assign pwm_out = (duty_act == '1) || (cnt < duty_act);
  assign rdata   = addr ? (ovr_en ? duty_act : duty_reg) : pre_reg;

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> cnt == $past(cnt) + 1'b1);
  p_cnt_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !div_tick |=> $stable(cnt));
  p_pcnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= pre_act[PW-1:0]);
  p_hold_midper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_act) && $stable(pre_act));
  p_wr_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr) |=> duty_reg == $past(wdata));
  p_zero_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> !pwm_out);
  p_ovr_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ovr_en) |=> duty_act == $past(ovr_duty));
endmodule

// File: tb/sim_fan_pwm_gen.sv
module sim_fan_pwm_gen;
  logic clk = 0, rst_n = 0, tick_fast = 1, tick_slow = 0;
  logic wr_en = 0, addr = 0, ovr_en = 0;
  logic [7:0] wdata = 0, ovr_duty = 0, rdata;
  logic pwm_out;
  int checks = 0, failures = 0;

  fan_pwm_gen u0 (.clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .ovr_en(ovr_en),
    .ovr_duty(ovr_duty), .pwm_out(pwm_out));

  always #2 clk = ~clk;

  initial forever begin
    repeat (7) @(negedge clk);
    tick_slow = 1;
    @(negedge clk);
    tick_slow = 0;
  end

  // {pre, duty, period cycles, high cycles}
  localparam logic [47:0] TBL [0:7] = '{
    {8'h00, 8'h80, 16'd256,   16'd128},   // R1
    {8'h00, 8'h00, 16'd256,   16'd0},     // R2
    {8'h03, 8'h40, 16'd1024,  16'd256},   // R5
    {8'h00, 8'h01, 16'd256,   16'd1},     // R1
    {8'h81, 8'h10, 16'd4096,  16'd256},   // R4
    {8'h80, 8'hFE, 16'd2048,  16'd2032},  // R4
    {8'h02, 8'hFF, 16'd768,   16'd768},   // R3
    {8'h7F, 8'h02, 16'd32768, 16'd256}    // R5
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic measure(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int h, oldp;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd(0, d); chk("R6 pre", d, 8'h01);
    rd(1, d); chk("R6 duty", d, 8'hFF);
    measure(512, h); chk("R6 high", h, 512);
    oldp = 512;
    for (int k = 0; k < 8; k++) begin
      wr(0, TBL[k][47:40]);
      wr(1, TBL[k][39:32]);
      rd(0, d); chk("R7 pre", d, TBL[k][47:40]);
      rd(1, d); chk("R7 duty", d, TBL[k][39:32]);
      repeat (oldp + 4) @(negedge clk);
      measure(int'(TBL[k][31:16]), h);
      chk("R1 R2 R3 R4 R5 highs", h, int'(TBL[k][15:0]));
      oldp = int'(TBL[k][31:16]);
    end
    // R8: mid-period write waits for the next period
    wr(0, 8'h00); wr(1, 8'h80);
    repeat (oldp + 300) @(negedge clk);
    @(negedge clk);
    while (pwm_out) @(negedge clk);
    while (!pwm_out) @(negedge clk);
    repeat (10) @(negedge clk);
    wr(1, 8'h20);
    repeat (88) @(negedge clk);
    chk("R8 old duty held", pwm_out, 1);
    repeat (300) @(negedge clk);
    measure(256, h); chk("R8 new duty", h, 32);
    // R9: override
    ovr_duty = 8'h40; ovr_en = 1;
    repeat (260) @(negedge clk);
    rd(1, d); chk("R9 read in-use", d, 8'h40);
    rd(0, d); chk("R9 pre unaffected", d, 8'h00);
    measure(256, h); chk("R9 ovr highs", h, 64);
    ovr_en = 0;
    rd(1, d); chk("R9 stored read", d, 8'h20);
    repeat (260) @(negedge clk);
    measure(256, h); chk("R9 release", h, 32);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule